// File: doc/BRIEF.md
# Transactional Line-Tracking Data Cache

This block is a small direct-mapped, write-back data cache for one core that lets the core run memory transactions. Each cache line holds one data word and, next to the usual valid and modified bits, two tracking marks: a read mark (the line is in the transaction's read set) and a speculative-write mark (the line is in its write set). Transactional loads and stores set these marks. A transactional store changes only the cached copy, so the new value stays hidden from memory until the transaction commits.

A snoop input reports line addresses that other agents read or write. When a snooped access collides with the current read or write set, a sticky doom flag is set at once (eager detection). Evicting a marked line to make room for another address also sets that flag, because the set can no longer be tracked. A commit then either turns every speculative line into an ordinary modified line in one cycle, or, if the transaction is doomed, drops them all. Abort always drops the write set. Validate reports whether the transaction is still alive, and when it is not, it drops the write set at once.

The core issues one request per cycle and gets a registered response one cycle later. The backing memory has a combinational read port and a write port that the memory samples on the clock edge.

Top module: `tmc_cache`

## Requirements
- R1: A request with `req_op` other than 0 (codes: 0 idle, 1 load, 2 transactional load, 3 transactional load-exclusive, 4 transactional store, 5 commit, 6 abort, 7 validate) produces `rsp_valid` high in exactly the next cycle. Idle cycles produce `rsp_valid` low.
- R2: A load of either kind returns the cached word on a hit, or the memory word on a miss. The line index is the low log2(LINES) address bits and the tag is the rest. A transaction sees its own speculative stores.
- R3: A transactional load puts the line in the read set. A transactional load-exclusive puts it in both the read and the write set.
- R4: A transactional store never writes its own value to memory. If the target line holds a modified committed value, that value is written to memory in the same cycle before the line turns speculative.
- R5: Commit of a live transaction returns `rsp_ok`=1. Every speculative line becomes modified, and a later eviction writes its value to memory.
- R6: Commit of a doomed transaction returns `rsp_ok`=0. Every speculative line is invalidated, so a later load returns the memory value.
- R7: Abort returns `rsp_ok`=1, invalidates every speculative line and clears all marks and the doom flag.
- R8: Validate returns `rsp_ok`=1 while the transaction is live. When it is doomed, validate returns 0, drops the write set at once and leaves the doom flag set until the next commit or abort.
- R9: A snooped write to a line in the read or write set, or a snooped read to a line in the write set, dooms the transaction. A snooped read of a read-only line, or a snoop whose tag differs, does not.
- R10: A miss that evicts a line carrying either mark dooms the transaction, and the response of that access already has `rsp_ok`=0.
- R11: A miss that evicts a modified, unmarked line writes that line back to memory in the same cycle. Memory is written only during access requests.
- R12: Transactional accesses return `rsp_ok` equal to "not doomed", counting events in the same cycle. Plain loads always return 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 3 | Request code |
| req_addr | input | ADDR_W | Word address of the access |
| req_wdata | input | DATA_W | Store data |
| rsp_valid | output | 1 | Response present |
| rsp_ok | output | 1 | Success / live flag |
| rsp_data | output | DATA_W | Load data |
| snp_valid | input | 1 | Remote access observed |
| snp_write | input | 1 | 1 = remote write, 0 = remote read |
| snp_addr | input | ADDR_W | Remote access address |
| mem_rd_addr | output | ADDR_W | Backing memory read address |
| mem_rd_data | input | DATA_W | Backing memory read data (combinational) |
| mem_we | output | 1 | Backing memory write enable |
| mem_wr_addr | output | ADDR_W | Backing memory write address |
| mem_wr_data | output | DATA_W | Backing memory write data |

## Verification
A mark that is lost or stuck shows up at the next commit or validate. The response flag comes out wrong one cycle after that request, or a snoop that should doom the transaction has no effect. A speculative value that leaks shows up in the memory model in the same cycle as the offending store or eviction. A write set that is not discarded shows up as a stale value on the very next load of that address. Each scenario therefore ends with a commit, validate or load that makes the hidden line state visible within one or two cycles.

// File: rtl/tmc_pkg.sv
package tmc_pkg;
  typedef enum logic [2:0] {
    OP_NOP      = 3'd0,
    OP_LOAD     = 3'd1,
    OP_TLOAD    = 3'd2,
    OP_TLOADX   = 3'd3,
    OP_TSTORE   = 3'd4,
    OP_COMMIT   = 3'd5,
    OP_ABORT    = 3'd6,
    OP_VALIDATE = 3'd7
  } tmc_op_e;
endpackage

// File: rtl/tmc_snoop_check.sv
module tmc_snoop_check #(
  parameter int LINES = 4,
  parameter int IDX_W = 2,
  parameter int TAG_W = 6
) (
  input  logic                        snp_valid,
  input  logic                        snp_write,
  input  logic [IDX_W-1:0]            snp_idx,
  input  logic [TAG_W-1:0]            snp_tag,
  input  logic [LINES-1:0]            valid_vec,
  input  logic [LINES-1:0]            rd_mark,
  input  logic [LINES-1:0]            wr_mark,
  input  logic [LINES-1:0][TAG_W-1:0] tag_vec,
  output logic                        conflict
);
  logic match;
  assign match = snp_valid && valid_vec[snp_idx] && (tag_vec[snp_idx] == snp_tag);
  // a remote write collides with either set, a remote read only with the write set
  assign conflict = match && (snp_write ? (rd_mark[snp_idx] | wr_mark[snp_idx])
                                        : wr_mark[snp_idx]);
endmodule

// File: rtl/tmc_set_finish.sv
module tmc_set_finish #(
  parameter int LINES = 4
) (
  input  logic             publish,
  input  logic             discard,
  input  logic [LINES-1:0] valid_in,
  input  logic [LINES-1:0] modf_in,
  input  logic [LINES-1:0] rd_in,
  input  logic [LINES-1:0] wr_in,
  output logic [LINES-1:0] valid_out,
  output logic [LINES-1:0] modf_out,
  output logic [LINES-1:0] rd_out,
  output logic [LINES-1:0] wr_out
);
  for (genvar g = 0; g < LINES; g++) begin : g_line
    always_comb begin
      valid_out[g] = valid_in[g];
      modf_out[g]  = modf_in[g];
      rd_out[g]    = rd_in[g];
      wr_out[g]    = wr_in[g];
      if (publish) begin
        modf_out[g] = modf_in[g] | wr_in[g];
        rd_out[g]   = 1'b0;
        wr_out[g]   = 1'b0;
      end else if (discard) begin
        valid_out[g] = valid_in[g] & ~wr_in[g];
        rd_out[g]    = 1'b0;
        wr_out[g]    = 1'b0;
      end
    end
  end
endmodule

// File: rtl/tmc_cache.sv
module tmc_cache #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int LINES  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [2:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic              rsp_ok,
  output logic [DATA_W-1:0] rsp_data,
  input  logic              snp_valid,
  input  logic              snp_write,
  input  logic [ADDR_W-1:0] snp_addr,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic [DATA_W-1:0] mem_rd_data,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_wr_addr,
  output logic [DATA_W-1:0] mem_wr_data
);
  import tmc_pkg::*;

  localparam int IDX_W = (LINES > 1) ? $clog2(LINES) : 1;
  localparam int TAG_W = ADDR_W - IDX_W;

  function automatic logic [IDX_W-1:0] addr_idx(input logic [ADDR_W-1:0] a);
    return a[IDX_W-1:0];
  endfunction

  function automatic logic [TAG_W-1:0] addr_tag(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:IDX_W];
  endfunction

  function automatic logic [ADDR_W-1:0] join_addr(input logic [TAG_W-1:0] t,
                                                  input logic [IDX_W-1:0] i);
    return {t, i};
  endfunction

  logic [LINES-1:0]             valid_q, modf_q, txr_q, txd_q;
  logic [LINES-1:0][TAG_W-1:0]  tag_q;
  logic [LINES-1:0][DATA_W-1:0] data_q;
  logic                         doomed_q;

  tmc_op_e           op;
  logic [IDX_W-1:0]  ridx;
  logic [TAG_W-1:0]  rtag;
  logic              is_acc, is_load, is_tx, hit, miss;
  logic              cap_evict, victim_wb, pre_wb, snp_conflict, doom_n;
  logic              commit_ok, set_discard, tx_end;
  logic [DATA_W-1:0] fill_data;
  logic [LINES-1:0]  fin_valid, fin_modf, fin_rd, fin_wr;

  assign op      = tmc_op_e'(req_op);
  assign ridx    = addr_idx(req_addr);
  assign rtag    = addr_tag(req_addr);
  assign is_load = req_valid && (op == OP_LOAD || op == OP_TLOAD || op == OP_TLOADX);
  assign is_acc  = is_load || (req_valid && op == OP_TSTORE);
  assign is_tx   = op == OP_TLOAD || op == OP_TLOADX || op == OP_TSTORE;
  assign hit     = valid_q[ridx] && (tag_q[ridx] == rtag);
  assign miss    = is_acc && !hit;

  // losing a marked line loses track of the set
  assign cap_evict = miss && valid_q[ridx] && (txr_q[ridx] || txd_q[ridx]);
  assign victim_wb = miss && valid_q[ridx] && modf_q[ridx];
  // committed value goes out before the line turns speculative
  assign pre_wb    = req_valid && (op == OP_TSTORE || op == OP_TLOADX) && hit && modf_q[ridx];

  assign mem_rd_addr = req_addr;
  assign mem_we      = victim_wb || pre_wb;
  assign mem_wr_addr = victim_wb ? join_addr(tag_q[ridx], ridx) : req_addr;
  assign mem_wr_data = data_q[ridx];
  assign fill_data   = hit ? data_q[ridx] : mem_rd_data;

  tmc_snoop_check #(.LINES(LINES), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_snoop (
    .snp_valid (snp_valid),
    .snp_write (snp_write),
    .snp_idx   (addr_idx(snp_addr)),
    .snp_tag   (addr_tag(snp_addr)),
    .valid_vec (valid_q),
    .rd_mark   (txr_q),
    .wr_mark   (txd_q),
    .tag_vec   (tag_q),
    .conflict  (snp_conflict)
  );

  assign doom_n      = doomed_q || snp_conflict || cap_evict;
  assign commit_ok   = req_valid && op == OP_COMMIT && !doom_n;
  assign set_discard = req_valid && (op == OP_ABORT ||
                       ((op == OP_COMMIT || op == OP_VALIDATE) && doom_n));
  assign tx_end      = req_valid && (op == OP_COMMIT || op == OP_ABORT);

  tmc_set_finish #(.LINES(LINES)) u_finish (
    .publish   (commit_ok),
    .discard   (set_discard),
    .valid_in  (valid_q),
    .modf_in   (modf_q),
    .rd_in     (txr_q),
    .wr_in     (txd_q),
    .valid_out (fin_valid),
    .modf_out  (fin_modf),
    .rd_out    (fin_rd),
    .wr_out    (fin_wr)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q   <= '0;
      modf_q    <= '0;
      txr_q     <= '0;
      txd_q     <= '0;
      tag_q     <= '0;
      data_q    <= '0;
      doomed_q  <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_ok    <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= req_valid && op != OP_NOP;
      rsp_data  <= is_load ? fill_data : '0;
      rsp_ok    <= (op == OP_LOAD || op == OP_ABORT) ? 1'b1 : !doom_n;
      doomed_q  <= tx_end ? 1'b0 : doom_n;
      valid_q   <= fin_valid;
      modf_q    <= fin_modf;
      txr_q     <= fin_rd;
      txd_q     <= fin_wr;
      if (is_acc) begin
        valid_q[ridx] <= 1'b1;
        tag_q[ridx]   <= rtag;
        data_q[ridx]  <= fill_data;
        if (miss) begin
          modf_q[ridx] <= 1'b0;
          txr_q[ridx]  <= 1'b0;
          txd_q[ridx]  <= 1'b0;
        end
        if (is_tx) begin
          if (op != OP_TSTORE) txr_q[ridx] <= 1'b1;
          if (op != OP_TLOAD) begin
            txd_q[ridx]  <= 1'b1;
            modf_q[ridx] <= 1'b0;
          end
          if (op == OP_TSTORE) data_q[ridx] <= req_wdata;
        end
      end
    end
  end
endmodule

// File: rtl/tmc_cache_chk.sv
module tmc_cache_chk #(
  parameter int LINES = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic [2:0]       req_op,
  input logic             rsp_valid,
  input logic             rsp_ok,
  input logic             doomed,
  input logic             snp_conflict,
  input logic             cap_evict,
  input logic [LINES-1:0] rd_marks,
  input logic [LINES-1:0] wr_marks,
  input logic             mem_we
);
  logic is_req, is_commit, is_abort, is_val, is_acc;
  assign is_req    = req_valid && req_op != 3'd0;
  assign is_commit = req_valid && req_op == 3'd5;
  assign is_abort  = req_valid && req_op == 3'd6;
  assign is_val    = req_valid && req_op == 3'd7;
  assign is_acc    = req_valid && req_op >= 3'd1 && req_op <= 3'd4;

  // R1
  resp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_req |=> rsp_valid);
  // R1
  no_resp_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !is_req |=> !rsp_valid);
  // R9
  snoop_hit_fails_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_conflict && is_commit) |=> !rsp_ok);
  // R10
  evict_dooms_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evict |=> doomed);
  // R7
  abort_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_abort |=> (rsp_ok && !doomed && $countones(rd_marks | wr_marks) == 0));
  // R5
  commit_clears_marks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_commit |=> (!doomed && $countones(rd_marks | wr_marks) == 0));
  // R8
  doomed_validate_fails_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (is_val && doomed) |=> (!rsp_ok && doomed && $countones(wr_marks) == 0));
  // R11
  mem_write_on_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> is_acc);
endmodule

bind tmc_cache tmc_cache_chk #(.LINES(LINES)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid    (req_valid),
  .req_op       (req_op),
  .rsp_valid    (rsp_valid),
  .rsp_ok       (rsp_ok),
  .doomed       (doomed_q),
  .snp_conflict (snp_conflict),
  .cap_evict    (cap_evict),
  .rd_marks     (txr_q),
  .wr_marks     (txd_q),
  .mem_we       (mem_we)
);

// File: tb/tb_tmc_cache.sv
module tb_tmc_cache;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic [2:0] req_op = '0;
  logic [7:0] req_addr = '0, req_wdata = '0;
  logic       rsp_valid, rsp_ok;
  logic [7:0] rsp_data;
  logic       snp_valid = 1'b0, snp_write = 1'b0;
  logic [7:0] snp_addr = '0;
  logic [7:0] mem_rd_addr, mem_rd_data, mem_wr_addr, mem_wr_data;
  logic       mem_we;
  logic [7:0] mem [256];

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic       r_ok;
  logic [7:0] r_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  tmc_cache dut (.*);

  function automatic logic [7:0] init_val(input int a);
    return 8'(a) ^ 8'h5A;
  endfunction

  initial for (int i = 0; i < 256; i++) mem[i] = init_val(i);
  assign mem_rd_data = mem[mem_rd_addr];
  always @(posedge clk) if (mem_we) mem[mem_wr_addr] <= mem_wr_data;

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [2:0] opc, input logic [7:0] a, input logic [7:0] d);
    req_valid = 1'b1; req_op = opc; req_addr = a; req_wdata = d;
    @(posedge clk); #1;
    req_valid = 1'b0; req_op = 3'd0;
    check("R1 rsp_valid", int'(rsp_valid), 1);
    r_ok = rsp_ok; r_data = rsp_data;
  endtask

  task automatic snoop(input logic w, input logic [7:0] a);
    snp_valid = 1'b1; snp_write = w; snp_addr = a;
    @(posedge clk); #1;
    snp_valid = 1'b0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(posedge clk); #1;
    check("R1 reset rsp_valid", int'(rsp_valid), 0);
    check("R11 reset mem_we", int'(mem_we), 0);
    rst_n = 1'b1;
    @(posedge clk); #1;
    check("R1 idle rsp_valid", int'(rsp_valid), 0);

    // R2 plain load misses on every index
    for (int i = 0; i < 4; i++) begin
      issue(3'd1, 8'(8'h10 + i), 8'h0);
      check("R2 load miss data", int'(r_data), int'(init_val(8'h10 + i)));
      check("R12 plain load ok", int'(r_ok), 1);
    end
    issue(3'd1, 8'h14, 8'h0);
    check("R2 clean eviction data", int'(r_data), int'(init_val(8'h14)));
    check("R11 clean line not written", int'(mem[8'h10]), int'(init_val(8'h10)));

    // R4/R5 speculative stores, commit, write-back on eviction
    for (int i = 0; i < 4; i++) begin
      issue(3'd4, 8'(8'h20 + i), 8'(8'hA0 + i));
      check("R12 tstore ok", int'(r_ok), 1);
      check("R4 memory untouched", int'(mem[8'h20 + i]), int'(init_val(8'h20 + i)));
    end
    for (int i = 0; i < 4; i++) begin
      issue(3'd2, 8'(8'h20 + i), 8'h0);
      check("R2 own speculative value", int'(r_data), int'(8'hA0 + i));
    end
    issue(3'd5, 8'h0, 8'h0);
    check("R5 commit ok", int'(r_ok), 1);
    for (int i = 0; i < 4; i++) begin
      check("R5 not written before eviction", int'(mem[8'h20 + i]), int'(init_val(8'h20 + i)));
      issue(3'd1, 8'(8'h24 + i), 8'h0);
      check("R11 evict load data", int'(r_data), int'(init_val(8'h24 + i)));
      check("R5 committed write-back", int'(mem[8'h20 + i]), int'(8'hA0 + i));
    end

    // R7 abort discards
    issue(3'd4, 8'h30, 8'h77);
    issue(3'd6, 8'h0, 8'h0);
    check("R7 abort ok", int'(r_ok), 1);
    issue(3'd1, 8'h30, 8'h0);
    check("R7 value discarded", int'(r_data), int'(init_val(8'h30)));

    // R4 store onto a modified committed line
    issue(3'd4, 8'h31, 8'h11);
    issue(3'd5, 8'h0, 8'h0);
    check("R5 commit ok", int'(r_ok), 1);
    issue(3'd4, 8'h31, 8'h22);
    check("R4 committed value written first", int'(mem[8'h31]), 8'h11);
    issue(3'd6, 8'h0, 8'h0);
    issue(3'd1, 8'h31, 8'h0);
    check("R4 committed value kept", int'(r_data), 8'h11);

    // R9 remote write to read set
    issue(3'd2, 8'h32, 8'h0);
    snoop(1'b1, 8'h32);
    issue(3'd7, 8'h0, 8'h0);
    check("R8 validate after conflict", int'(r_ok), 0);
    issue(3'd5, 8'h0, 8'h0);
    check("R6 doomed commit", int'(r_ok), 0);
    issue(3'd7, 8'h0, 8'h0);
    check("R8 fresh validate", int'(r_ok), 1);

    // R9 remote read to read-only line
    issue(3'd2, 8'h33, 8'h0);
    snoop(1'b0, 8'h33);
    issue(3'd5, 8'h0, 8'h0);
    check("R9 read-read no conflict", int'(r_ok), 1);

    // R9/R6 remote read to written line
    issue(3'd4, 8'h32, 8'h99);
    snoop(1'b0, 8'h32);
    issue(3'd5, 8'h0, 8'h0);
    check("R6 commit after read conflict", int'(r_ok), 0);
    issue(3'd1, 8'h32, 8'h0);
    check("R6 discarded value", int'(r_data), int'(init_val(8'h32)));

    // R3 load-exclusive joins the write set
    issue(3'd3, 8'h33, 8'h0);
    check("R3 loadx data", int'(r_data), int'(init_val(8'h33)));
    snoop(1'b0, 8'h33);
    issue(3'd7, 8'h0, 8'h0);
    check("R3 loadx conflicts with remote read", int'(r_ok), 0);
    issue(3'd6, 8'h0, 8'h0);

    // R10 capacity eviction
    issue(3'd2, 8'h40, 8'h0);
    check("R12 tload ok", int'(r_ok), 1);
    issue(3'd2, 8'h44, 8'h0);
    check("R10 evicting access fails", int'(r_ok), 0);
    check("R10 data still returned", int'(r_data), int'(init_val(8'h44)));
    issue(3'd7, 8'h0, 8'h0);
    check("R10 validate after eviction", int'(r_ok), 0);
    issue(3'd6, 8'h0, 8'h0);

    // R8 failed validate discards immediately
    issue(3'd4, 8'h41, 8'h55);
    snoop(1'b1, 8'h41);
    issue(3'd7, 8'h0, 8'h0);
    check("R8 validate fails", int'(r_ok), 0);
    issue(3'd1, 8'h41, 8'h0);
    check("R8 write set dropped", int'(r_data), int'(init_val(8'h41)));
    issue(3'd5, 8'h0, 8'h0);
    check("R8 doom persists to commit", int'(r_ok), 0);

    // R9 different tag on same index
    issue(3'd2, 8'h42, 8'h0);
    snoop(1'b1, 8'h46);
    issue(3'd5, 8'h0, 8'h0);
    check("R9 tag mismatch no conflict", int'(r_ok), 1);

    @(posedge clk); #1;
    check("R1 idle after traffic", int'(rsp_valid), 0);
    finish_run();
  end
endmodule